// File: doc/BRIEF.md
# Multi-Mode Serial Audio Transmitter

This block is the transmit half of a serial audio port. It takes parallel sample words from a valid/ready source and shifts them out MSB first on one serial data line. It generates the bit clock and the frame sync itself, from the system clock. Two framing families share one shifter. The first is a DSP-style framing with a one-bit frame-sync pulse per word. The second is a paired-channel audio framing with two 32-bit slots per frame, which runs either in I2S timing or in left-justified timing.

The mode inputs are expected to stay constant while the transmitter is enabled. A channel-order bit picks which channel goes out first in I2S timing. In left-justified timing, the same bit picks the frame-sync edge that opens a sample pair. The word length is programmable. A setting outside the legal range for the selected framing is clamped and reported. If no suitable word is waiting when a word starts, zeros are sent and a sticky underflow flag is raised.

Top module: `serial_audio_tx`

## Requirements
- R1: With `cfg_paired`=0 (DSP framing), a frame lasts 1+W bit periods, where W is the effective word length. `fs_o` is high only during the first of these periods, which is the period just before the MSB. The W data bits follow, and `s_right` is ignored.
- R2: In DSP framing, `cfg_fsel` has no effect on `fs_o`, `sd_o` or `s_ready`.
- R3: With `cfg_paired`=1 and `cfg_ljust`=0 (I2S), a frame is 64 bit periods made of two 32-period slots. `fs_o`=1 marks the right-channel slot, and it switches one bit period before that slot's MSB. `cfg_fsel`=1 sends the left slot first and `cfg_fsel`=0 sends the right slot first.
- R4: With `cfg_paired`=1 and `cfg_ljust`=1 (left-justified), the first slot carries left and the second carries right. `fs_o` switches in the same bit period as the slot's MSB. `cfg_fsel`=0 holds `fs_o` high in the first slot, so a rising edge opens the pair. `cfg_fsel`=1 holds it low in the first slot, so a falling edge opens the pair.
- R5: Bits go out MSB first. Only the low W bits of `s_data` are sent. Every slot position after the W-th bit carries 0.
- R6: `sclk_o` has a half period of max(floor(`cfg_div`/2),1) system cycles. It is low after enable and rises first after one half period. `sd_o` and `fs_o` change only at the system edge where `sclk_o` falls.
- R7: The effective W is `cfg_wlen` clamped to 3..32 in DSP framing and to 8..32 in the audio framings. `cfg_err_o` is high one cycle after any cycle whose setting needed clamping.
- R8: `s_ready` is high for exactly one system cycle, in the cycle whose edge drives a word's MSB. In the audio framings it is high only when `s_right` (1 = right) matches the channel of the starting slot. A word that does not match stays pending.
- R9: When a word starts and no word is accepted, the word is sent as zeros and `underflow_o` rises one cycle later. It then holds until a `uf_clear` pulse. If a clear and a new underflow arrive together, the new underflow wins.
- R10: During reset and while `cfg_en`=0, `sclk_o`, `fs_o` and `sd_o` are 0. Reset also clears both flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_en | input | 1 | Run enable; 0 parks the transmitter |
| cfg_paired | input | 1 | 0 = DSP framing, 1 = paired-channel audio framing |
| cfg_ljust | input | 1 | In audio framing: 0 = I2S, 1 = left-justified |
| cfg_fsel | input | 1 | Channel order (I2S) or opening frame-sync edge (left-justified) |
| cfg_wlen | input | 6 | Requested word length in bits |
| cfg_div | input | 8 | Bit-clock divisor in system cycles |
| s_valid | input | 1 | Source holds a word |
| s_data | input | 32 | Word, right-aligned |
| s_right | input | 1 | Channel tag, 1 = right |
| s_ready | output | 1 | Word taken this cycle |
| sclk_o | output | 1 | Bit clock |
| fs_o | output | 1 | Frame sync |
| sd_o | output | 1 | Serial data |
| underflow_o | output | 1 | Sticky underflow flag |
| uf_clear | input | 1 | Write-one-to-clear pulse for the underflow flag |
| cfg_err_o | output | 1 | Word-length setting was clamped |

## Verification
`sd_o` and `fs_o` are registered, and they update at the same system edge that drives `sclk_o` low. `s_ready` is combinational and is valid during the cycle before that edge. Both flags appear one cycle after their cause. The bench steps a behavioural model at every rising edge using the inputs held since the previous falling edge. It then compares the registered outputs at the following falling edge. `s_ready` is compared one time step after new inputs are driven, so every expected value lines up with the edge that produces it.

// File: rtl/sat_pkg.sv
package sat_pkg;

  typedef enum logic [1:0] {
    FR_DSP = 2'd0,
    FR_I2S = 2'd1,
    FR_LJ  = 2'd2
  } frame_e;

  function automatic frame_e pick_frame(input logic paired, input logic ljust);
    if (!paired)    return FR_DSP;
    else if (ljust) return FR_LJ;
    else            return FR_I2S;
  endfunction

  function automatic logic [7:0] clamp_len(input logic [7:0] raw,
                                           input logic [7:0] lo,
                                           input logic [7:0] hi);
    if (raw < lo)      return lo;
    else if (raw > hi) return hi;
    else               return raw;
  endfunction

endpackage

// File: rtl/sat_clkgen.sv
module sat_clkgen #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic [DIV_W-1:0] div,
  output logic             sclk,
  output logic             fall
);
  localparam logic [DIV_W-1:0] ONE = DIV_W'(1);

  logic [DIV_W-1:0] cnt;
  logic [DIV_W-1:0] half_raw;
  logic [DIV_W-1:0] half;
  logic             tick;

  assign half_raw = div >> 1;
  assign half     = (half_raw == '0) ? ONE : half_raw;
  assign tick     = en && (cnt >= half - ONE);
  assign fall     = tick && sclk;

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      cnt  <= '0;
      sclk <= 1'b0;
    end else if (tick) begin
      cnt  <= '0;
      sclk <= ~sclk;
    end else begin
      cnt  <= cnt + ONE;
    end
  end
endmodule

// File: rtl/sat_framer.sv
module sat_framer
  import sat_pkg::*;
#(
  parameter int LEN_W = 6,
  parameter int POS_W = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic             fall,
  input  frame_e           fr,
  input  logic             fsel,
  input  logic [LEN_W-1:0] wlen,
  output logic             fs,
  output logic             load,
  output logic             load_right
);
  logic [POS_W-1:0] pos;
  logic [POS_W-1:0] np;
  logic [POS_W-1:0] last;
  logic [POS_W-1:0] nxt1;
  logic             started;
  logic             slot;
  logic             fs_d;
  logic             is_load;
  logic             ch;

  assign last = (fr == FR_DSP) ? POS_W'(wlen) : {POS_W{1'b1}};
  assign np   = !started ? '0 : ((pos == last) ? '0 : pos + POS_W'(1));
  assign nxt1 = np + POS_W'(1);
  assign slot = np[POS_W-1];

  always_comb begin
    fs_d    = 1'b0;
    is_load = 1'b0;
    ch      = 1'b0;
    case (fr)
      FR_I2S: begin
        fs_d    = nxt1[POS_W-1] ^ ~fsel;
        is_load = (np[POS_W-2:0] == '0);
        ch      = slot ^ ~fsel;
      end
      FR_LJ: begin
        fs_d    = slot ^ ~fsel;
        is_load = (np[POS_W-2:0] == '0);
        ch      = slot;
      end
      default: begin
        fs_d    = (np == '0);
        is_load = (np == POS_W'(1));
        ch      = 1'b0;
      end
    endcase
  end

  assign load       = fall && is_load;
  assign load_right = ch;

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      pos     <= '0;
      started <= 1'b0;
      fs      <= 1'b0;
    end else if (fall) begin
      pos     <= np;
      started <= 1'b1;
      fs      <= fs_d;
    end
  end
endmodule

// File: rtl/sat_shifter.sv
module sat_shifter #(
  parameter int DATA_W = 32,
  parameter int LEN_W  = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  logic              fall,
  input  logic              load,
  input  logic              take,
  input  logic [DATA_W-1:0] data,
  input  logic [LEN_W-1:0]  wlen,
  output logic              sd
);
  localparam int SHW = LEN_W + 1;

  logic [DATA_W-1:0] sreg;
  logic [DATA_W-1:0] aligned;
  logic [SHW-1:0]    sh;

  assign sh      = SHW'(DATA_W) - {1'b0, wlen};
  assign aligned = take ? (data << sh) : '0;

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      sreg <= '0;
      sd   <= 1'b0;
    end else if (fall) begin
      if (load) begin
        sd   <= aligned[DATA_W-1];
        sreg <= aligned << 1;
      end else begin
        sd   <= sreg[DATA_W-1];
        sreg <= sreg << 1;
      end
    end
  end
endmodule

// File: rtl/serial_audio_tx.sv
module serial_audio_tx
  import sat_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int DIV_W  = 8,
  parameter int LEN_W  = $clog2(DATA_W + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_en,
  input  logic              cfg_paired,
  input  logic              cfg_ljust,
  input  logic              cfg_fsel,
  input  logic [LEN_W-1:0]  cfg_wlen,
  input  logic [DIV_W-1:0]  cfg_div,
  input  logic              s_valid,
  input  logic [DATA_W-1:0] s_data,
  input  logic              s_right,
  output logic              s_ready,
  output logic              sclk_o,
  output logic              fs_o,
  output logic              sd_o,
  output logic              underflow_o,
  input  logic              uf_clear,
  output logic              cfg_err_o
);
  localparam int         POS_W   = $clog2(2 * DATA_W);
  localparam logic [7:0] MIN_DSP = 8'd3;
  localparam logic [7:0] MIN_AUD = 8'd8;
  localparam logic [7:0] MAX_LEN = 8'(DATA_W);

  frame_e           fr;
  logic [7:0]       raw8;
  logic [7:0]       clamped;
  logic [LEN_W-1:0] eff_wlen;
  logic             bad_len;
  logic             fall;
  logic             load;
  logic             load_right;
  logic             take;

  assign fr       = pick_frame(cfg_paired, cfg_ljust);
  assign raw8     = 8'(cfg_wlen);
  assign clamped  = clamp_len(raw8, (fr == FR_DSP) ? MIN_DSP : MIN_AUD, MAX_LEN);
  assign eff_wlen = clamped[LEN_W-1:0];
  assign bad_len  = (clamped != raw8);

  sat_clkgen #(.DIV_W(DIV_W)) u_clk (
    .clk  (clk),
    .rst  (rst),
    .en   (cfg_en),
    .div  (cfg_div),
    .sclk (sclk_o),
    .fall (fall)
  );

  sat_framer #(.LEN_W(LEN_W), .POS_W(POS_W)) u_frm (
    .clk        (clk),
    .rst        (rst),
    .en         (cfg_en),
    .fall       (fall),
    .fr         (fr),
    .fsel       (cfg_fsel),
    .wlen       (eff_wlen),
    .fs         (fs_o),
    .load       (load),
    .load_right (load_right)
  );

  assign s_ready = load && ((fr == FR_DSP) || (s_right == load_right));
  assign take    = s_valid && s_ready;

  sat_shifter #(.DATA_W(DATA_W), .LEN_W(LEN_W)) u_shf (
    .clk  (clk),
    .rst  (rst),
    .en   (cfg_en),
    .fall (fall),
    .load (load),
    .take (take),
    .data (s_data),
    .wlen (eff_wlen),
    .sd   (sd_o)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      underflow_o <= 1'b0;
      cfg_err_o   <= 1'b0;
    end else begin
      cfg_err_o <= bad_len;
      if (load && !take)  underflow_o <= 1'b1;
      else if (uf_clear)  underflow_o <= 1'b0;
    end
  end
endmodule

// File: rtl/sat_tx_checks.sv
module sat_tx_checks (
  input logic clk,
  input logic rst,
  input logic cfg_en,
  input logic cfg_paired,
  input logic sclk_o,
  input logic fs_o,
  input logic sd_o,
  input logic s_ready,
  input logic underflow_o,
  input logic uf_clear
);
  a_r6_data_on_fall: assert property (@(posedge clk) disable iff (rst)
    (cfg_en && $past(cfg_en) && (sd_o != $past(sd_o))) |-> $fell(sclk_o));

  a_r8_ready_single: assert property (@(posedge clk) disable iff (rst)
    s_ready |=> !s_ready);

  a_r9_flag_sticky: assert property (@(posedge clk) disable iff (rst)
    (underflow_o && !uf_clear) |=> underflow_o);

  a_r10_parked_quiet: assert property (@(posedge clk) disable iff (rst)
    !cfg_en |=> (!sclk_o && !fs_o && !sd_o));

  a_r1_pulse_one_bit: assert property (@(posedge clk) disable iff (rst)
    (cfg_en && $past(cfg_en) && !cfg_paired && !$past(cfg_paired) &&
     $fell(sclk_o) && $past(fs_o)) |-> !fs_o);
endmodule

bind serial_audio_tx sat_tx_checks u_chk (
  .clk         (clk),
  .rst         (rst),
  .cfg_en      (cfg_en),
  .cfg_paired  (cfg_paired),
  .sclk_o      (sclk_o),
  .fs_o        (fs_o),
  .sd_o        (sd_o),
  .s_ready     (s_ready),
  .underflow_o (underflow_o),
  .uf_clear    (uf_clear)
);

// File: tb/tb_serial_audio_tx.sv
`timescale 1ns/1ps
module tb_serial_audio_tx;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_en = 1'b0, cfg_paired = 1'b0, cfg_ljust = 1'b0, cfg_fsel = 1'b0;
  logic [5:0]  cfg_wlen = 6'd8;
  logic [7:0]  cfg_div = 8'd2;
  logic        s_valid = 1'b0, s_right = 1'b0, uf_clear = 1'b0;
  logic [31:0] s_data = '0;
  logic        s_ready, sclk_o, fs_o, sd_o, underflow_o, cfg_err_o;

  always #2.5 clk = ~clk;

  serial_audio_tx dut (
    .clk(clk), .rst(rst), .cfg_en(cfg_en), .cfg_paired(cfg_paired),
    .cfg_ljust(cfg_ljust), .cfg_fsel(cfg_fsel), .cfg_wlen(cfg_wlen),
    .cfg_div(cfg_div), .s_valid(s_valid), .s_data(s_data), .s_right(s_right),
    .s_ready(s_ready), .sclk_o(sclk_o), .fs_o(fs_o), .sd_o(sd_o),
    .underflow_o(underflow_o), .uf_clear(uf_clear), .cfg_err_o(cfg_err_o)
  );

  int total = 0;
  int bad = 0;
  bit done = 0;
  string tag = "R10";
  logic [31:0] qd[$];
  bit          qr[$];

  int m_cnt, m_pos, m_k;
  bit m_bclk, m_started, m_fs, m_sd, m_uf, m_err;
  logic [31:0] m_word;

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h t=%0t", req, what, act, exp, $time);
    end
  endtask

  function automatic int f_h();
    int h = int'(cfg_div) / 2;
    return (h == 0) ? 1 : h;
  endfunction

  function automatic int f_w();
    int lo = cfg_paired ? 8 : 3;
    int w = int'(cfg_wlen);
    if (w < lo) w = lo;
    if (w > 32) w = 32;
    return w;
  endfunction

  function automatic int f_np();
    int last = cfg_paired ? 63 : f_w();
    if (!m_started) return 0;
    if (m_pos == last) return 0;
    return m_pos + 1;
  endfunction

  function automatic bit f_fall();
    return cfg_en && (m_cnt >= f_h() - 1) && m_bclk;
  endfunction

  function automatic bit f_isload(int np);
    return cfg_paired ? ((np % 32) == 0) : (np == 1);
  endfunction

  // channel of the slot holding position np, 1 = right
  function automatic bit f_chan(int np);
    bit second = (np >= 32);
    if (cfg_paired && !cfg_ljust) return cfg_fsel ? second : !second;
    return second;
  endfunction

  function automatic bit f_fs(int np);
    bit second = (np >= 32);
    if (!cfg_paired) return (np == 0);
    if (!cfg_ljust)  return f_chan((np + 1) % 64);
    return cfg_fsel ? second : !second;
  endfunction

  function automatic bit f_ready();
    int np = f_np();
    return f_fall() && f_isload(np) && (!cfg_paired || (s_right == f_chan(np)));
  endfunction

  task automatic model_idle();
    m_cnt = 0; m_bclk = 0; m_started = 0; m_pos = 0;
    m_fs = 0; m_sd = 0; m_word = '0; m_k = 1000;
  endtask

  task automatic model_edge();
    bit rdy, acc, ld;
    int np, w;
    if (rst) begin
      model_idle();
      m_uf = 0; m_err = 0;
      return;
    end
    rdy = f_ready();
    acc = rdy && s_valid;
    np  = f_np();
    ld  = f_fall() && f_isload(np);
    w   = f_w();
    m_err = (int'(cfg_wlen) != w);
    if (ld && !acc) m_uf = 1;
    else if (uf_clear) m_uf = 0;
    if (!cfg_en) begin
      model_idle();
    end else if (m_cnt >= f_h() - 1) begin
      m_cnt = 0;
      if (m_bclk) begin
        m_pos = np;
        m_started = 1;
        m_fs = f_fs(np);
        if (ld) begin
          m_word = acc ? s_data : 32'h0;
          m_k = 0;
        end else if (m_k < 1000) begin
          m_k++;
        end
        m_sd = (m_k < w) ? m_word[w-1-m_k] : 1'b0;
      end
      m_bclk = !m_bclk;
    end else begin
      m_cnt++;
    end
    if (acc) begin
      void'(qd.pop_front());
      void'(qr.pop_front());
    end
  endtask

  task automatic drive_inputs();
    s_valid = (qd.size() > 0);
    s_data  = (qd.size() > 0) ? qd[0] : 32'h0;
    s_right = (qr.size() > 0) ? qr[0] : 1'b0;
  endtask

  task automatic cyc();
    @(posedge clk);
    model_edge();
    @(negedge clk);
    chk(tag,   "sd_o",        {31'b0, sd_o},        {31'b0, m_sd});
    chk(tag,   "fs_o",        {31'b0, fs_o},        {31'b0, m_fs});
    chk("R6",  "sclk_o",      {31'b0, sclk_o},      {31'b0, m_bclk});
    chk("R9",  "underflow_o", {31'b0, underflow_o}, {31'b0, m_uf});
    chk("R7",  "cfg_err_o",   {31'b0, cfg_err_o},   {31'b0, m_err});
    uf_clear = 1'b0;
    drive_inputs();
    #1;
    chk("R8",  "s_ready",     {31'b0, s_ready},     {31'b0, f_ready()});
  endtask

  task automatic run(int n);
    for (int i = 0; i < n; i++) cyc();
  endtask

  task automatic push(logic [31:0] d, bit r);
    qd.push_back(d);
    qr.push_back(r);
    drive_inputs();
  endtask

  task automatic setcfg(bit paired, bit lj, bit fsel, int wlen, int div);
    cfg_en = 1'b0;
    qd.delete();
    qr.delete();
    drive_inputs();
    run(2);
    cfg_paired = paired; cfg_ljust = lj; cfg_fsel = fsel;
    cfg_wlen = 6'(wlen); cfg_div = 8'(div);
    run(1);
    cfg_en = 1'b1;
  endtask

  task automatic push_pairs(int n, bit first_right, logic [31:0] seed);
    for (int i = 0; i < n; i++) begin
      push(seed ^ (32'h01234567 * (i + 1)), first_right ^ i[0]);
    end
  endtask

  initial begin
    model_idle();
    m_uf = 0; m_err = 0;
    tag = "R10";
    run(4);
    chk("R10", "reset sd_o",        {31'b0, sd_o},        32'h0);
    chk("R10", "reset fs_o",        {31'b0, fs_o},        32'h0);
    chk("R10", "reset sclk_o",      {31'b0, sclk_o},      32'h0);
    chk("R10", "reset s_ready",     {31'b0, s_ready},     32'h0);
    chk("R10", "reset underflow_o", {31'b0, underflow_o}, 32'h0);
    rst = 1'b0;
    run(2);

    tag = "R1";  setcfg(0, 0, 0, 8, 2);  push_pairs(6, 0, 32'hA5C3_96E1); run(130);
    tag = "R2";  setcfg(0, 0, 1, 8, 2);  push_pairs(6, 1, 32'hA5C3_96E1); run(130);
    tag = "R7";  setcfg(0, 0, 0, 1, 2);  push_pairs(5, 0, 32'h0000_0005); run(60);
    tag = "R7";  setcfg(0, 0, 0, 40, 2); push_pairs(3, 0, 32'hDEAD_BEEF); run(230);
    tag = "R3";  setcfg(1, 0, 1, 16, 2); push_pairs(4, 0, 32'h1357_9BDF); run(300);
    tag = "R3";  setcfg(1, 0, 0, 16, 2); push_pairs(4, 1, 32'h2468_ACE0); run(300);
    tag = "R4";  setcfg(1, 1, 0, 24, 2); push_pairs(4, 0, 32'h0F1E_2D3C); run(300);
    tag = "R4";  setcfg(1, 1, 1, 24, 2); push_pairs(4, 0, 32'h4B5A_6978); run(300);
    tag = "R5";  setcfg(1, 0, 1, 32, 2); push_pairs(4, 0, 32'hFFFF_0001); run(300);
    tag = "R5";  setcfg(1, 1, 0, 12, 2); push_pairs(4, 0, 32'hFFFF_FFFF); run(300);
    tag = "R7";  setcfg(1, 0, 1, 4, 2);  push_pairs(4, 0, 32'h8765_4321); run(300);
    tag = "R8";  setcfg(1, 0, 1, 16, 2); push_pairs(5, 1, 32'hC001_D00D); run(400);
    tag = "R9";  setcfg(1, 1, 0, 16, 2); run(200);
    uf_clear = 1'b1; run(40);
    push_pairs(4, 0, 32'h5555_AAAA); run(20);
    uf_clear = 1'b1; run(300);
    uf_clear = 1'b1; run(5);
    tag = "R6";  setcfg(0, 0, 0, 6, 6);  push_pairs(3, 0, 32'h0000_0039); run(200);
    tag = "R6";  setcfg(1, 0, 1, 10, 7); push_pairs(2, 0, 32'h0000_03A5); run(500);
    tag = "R6";  setcfg(0, 0, 1, 5, 0);  push_pairs(4, 0, 32'h0000_0015); run(80);

    tag = "R10";
    cfg_en = 1'b0;
    run(20);
    uf_clear = 1'b1;
    run(3);
    rst = 1'b1;
    run(3);
    chk("R10", "sd_o after reset",        {31'b0, sd_o},        32'h0);
    chk("R10", "fs_o after reset",        {31'b0, fs_o},        32'h0);
    chk("R10", "underflow_o after reset", {31'b0, underflow_o}, 32'h0);
    chk("R10", "cfg_err_o after reset",   {31'b0, cfg_err_o},   32'h0);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL R10 watchdog actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule